// File: doc/BRIEF.md
# Serial Flash-Programming Session Sequencer

This block runs one complete erase-and-program session against a remote device over a byte-wide asynchronous serial link. A UART bit engine sits between the block and the wire. The block sees that engine only through a transmit valid/ready handshake and a receive strobe that carries a data byte and two error flags. The link itself is 8N1, LSB first, at 31,250 bit/s from a 50 MHz clock. A falling edge on the start switch input begins a session.

The block then works through four stages, and each stage ends by waiting for one acknowledge byte (0x55):
- a start command;
- an erase command followed by a block selector byte;
- a program command followed by the image length;
- the image itself, sent in 256-byte chunks, with each chunk acknowledged.

Image bytes are read from a local byte memory port. A short last chunk is filled out with 0xFF.

Four active-low LEDs report the result. A clean finish plays a one-pass chase. A link error, a wrong reply or a missing reply leaves an error code blinking.

Top module: `flash_prog_seq`

## Requirements
- R1: A session begins only when the synchronised `start_n` falls while the block is not busy. A low level held on `start_n` starts nothing further, and neither does a rising edge.
- R2: The first byte of a session is 0x10. Nothing more is transmitted until a reply is received.
- R3: After the reply 0x55, the block sends 0x11 and then the selector byte `{6'b0, erase_sel}`. The codes 0, 1, 2 and 3 name remote blocks 27, 26, 25 and 24. The block then waits for 0x55.
- R4: The block then sends 0x12 and the 32-bit `img_len`, most significant byte first. It then waits for 0x55.
- R5: Data goes out in chunks of exactly 256 bytes. Data byte k equals `mem_rdata` while `mem_addr` = k, for k < `img_len`. Any byte at k >= `img_len` is 0xFF. A 0x55 is awaited after every chunk. When `img_len` = 0, no chunk is sent.
- R6: `tx_data` is held stable with `tx_valid` high until `tx_ready` is seen. Only one byte is outstanding at a time.
- R7: `busy` is high from the accepted start edge until the block reaches the done state or the error state.
- R8: After reset, `led_n` = 4'b1111, and both `busy` and `tx_valid` are low.
- R9: On success, LED0, LED1, LED2 and LED3 light in that order, one at a time. Lighting LED i drives bit i of `led_n` low. Each step lasts `led_delay` cycles, and afterwards all LEDs stay off.
- R10: The error state is entered with a code:
  - code 1 when a receive strobe carries a framing or overrun flag during a session;
  - code 2 when a reply other than 0x55 arrives.

  In the error state, `led_n` alternates between ~code (LED i lit for code bit i) and 4'b1111, with each phase lasting `led_delay` cycles.
- R11: When no reply arrives within `ack_timeout`+1 cycles of waiting, the error state is entered with code 3.
- R12: A new start edge leaves the done state or the error state, clears the LEDs and runs a fresh session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_n | input | 1 | Start switch, active low, asynchronous |
| img_len | input | 32 | Image length in bytes, sampled at start |
| erase_sel | input | 2 | Erase block selector code, sampled at start |
| led_delay | input | 24 | Cycles per LED step |
| ack_timeout | input | 20 | Reply wait limit in cycles |
| tx_valid | output | 1 | Transmit byte offered |
| tx_ready | input | 1 | UART takes the offered byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | One-cycle receive strobe |
| rx_data | input | 8 | Received byte |
| rx_frame_err | input | 1 | Framing error with the strobe |
| rx_overrun | input | 1 | Overrun error with the strobe |
| mem_addr | output | 16 | Image byte address |
| mem_rdata | input | 8 | Image byte, read asynchronously |
| led_n | output | 4 | Status LEDs, active low |
| busy | output | 1 | Session in progress |

## Verification
The assertions assume three things about the inputs. First, `mem_rdata` is a pure function of `mem_addr` within the same cycle, so an offered data byte cannot change while it waits for `tx_ready`. Second, `rx_valid` is a single-cycle strobe. Third, the remote side sends nothing while the block is transmitting, apart from an error-flagged strobe. The stimulus models the image memory as a fixed arithmetic function of the address. It raises `rx_valid` for exactly one cycle, and only after the last byte of a stage has been taken, except in the directed test that injects an overrun mid-transmit. `img_len`, `erase_sel` and the two delay inputs are set before each start edge and are not touched during a session.

// File: rtl/fps_pkg.sv
`timescale 1ns/1ps
// Shared encodings of the session sequencer: state and stage types, link
// byte values and the error codes shown on the LEDs.
package fps_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_SEND, ST_WAIT, ST_DONE, ST_FAIL
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_HELLO, PH_ERASE, PH_LEN, PH_DATA
    } seq_phase_t;

    localparam logic [7:0] CMD_START = 8'h10;
    localparam logic [7:0] CMD_ERASE = 8'h11;
    localparam logic [7:0] CMD_PROG  = 8'h12;
    localparam logic [7:0] REPLY_OK  = 8'h55;
    localparam logic [7:0] PAD_BYTE  = 8'hFF;

    localparam logic [3:0] ERR_LINK  = 4'd1;
    localparam logic [3:0] ERR_NAK   = 4'd2;
    localparam logic [3:0] ERR_TMO   = 4'd3;
endpackage

// File: rtl/fps_start_edge.sv
`timescale 1ns/1ps
// Synchronises the asynchronous active-low start switch and emits a one-cycle
// pulse on each falling transition. The chain resets to "released" (high), so
// the switch is assumed released while reset is applied.
module fps_start_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);
    logic [SYNC_STAGES:0] chain;

    // chain[0] is the raw pin; each further stage is one flop
    assign chain[0] = pin_n;

    generate
        for (genvar g = 1; g <= SYNC_STAGES; g++) begin : g_sync
            // One synchroniser / history stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b1;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    // Fall pulse: older sample high, newer sample low
    assign fall = chain[SYNC_STAGES] & ~chain[SYNC_STAGES-1];

    // R1
    edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/fps_ack_timer.sv
`timescale 1ns/1ps
// Counts cycles spent waiting for a reply. It clears whenever the wait is not
// in progress and flags expiry once the count reaches the limit.
module fps_ack_timer #(
    parameter int TO_W = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [TO_W-1:0] limit,
    output logic            expired
);
    logic [TO_W-1:0] cnt;

    // Saturating wait counter, cleared outside a wait
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (!run)        cnt <= '0;
        else if (cnt < limit) cnt <= cnt + 1'b1;
    end

    // Expiry only while waiting and at or past the limit
    assign expired = run && (cnt >= limit);

    // R11
    tmo_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && limit != '0) |-> $past(run));
endmodule

// File: rtl/fps_led_show.sv
`timescale 1ns/1ps
// Drives the active-low status LEDs. A go pulse starts either a single-pass
// chase (one LED at a time) or an endless blink of an error code against
// all-off. Each step lasts 'delay' cycles; a delay of 0 acts as 1.
// A clear pulse turns everything off and has priority over go.
module fps_led_show #(
    parameter int DLY_W = 24,
    parameter int N_LED = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             go,
    input  logic             err_mode,
    input  logic [N_LED-1:0] code,
    input  logic [DLY_W-1:0] delay,
    output logic [N_LED-1:0] led_n
);
    localparam int IDX_W = (N_LED > 1) ? $clog2(N_LED) : 1;

    logic             active;
    logic             err_r;
    logic [N_LED-1:0] code_r;
    logic [IDX_W-1:0] idx;
    logic [DLY_W-1:0] dcnt;
    logic             step_end;

    // End of the current step: dcnt+1 has reached the programmed delay
    assign step_end = ({1'b0, dcnt} + 1'b1) >= {1'b0, delay};

    // Step sequencing for chase and blink
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            err_r  <= 1'b0;
            code_r <= '0;
            idx    <= '0;
            dcnt   <= '0;
        end else if (clear) begin
            active <= 1'b0;
        end else if (go) begin
            active <= 1'b1;
            err_r  <= err_mode;
            code_r <= code;
            idx    <= '0;
            dcnt   <= '0;
        end else if (active) begin
            if (step_end) begin
                dcnt <= '0;
                if (err_r)                              idx[0] <= ~idx[0];
                else if (idx == IDX_W'(N_LED - 1))      active <= 1'b0;
                else                                    idx    <= idx + 1'b1;
            end else begin
                dcnt <= dcnt + 1'b1;
            end
        end
    end

    // LED pattern from the current step
    always_comb begin
        led_n = '1;
        if (active) begin
            if (err_r) begin
                if (!idx[0]) led_n = ~code_r;
            end else begin
                led_n[idx] = 1'b0;
            end
        end
    end

    // R9
    chase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !err_r) |-> ($countones(~led_n) == 1));
endmodule

// File: rtl/flash_prog_seq.sv
`timescale 1ns/1ps
// Session sequencer for remote flash erase/program over a byte UART.
// It walks four stages (start, erase+selector, program+length, chunked data),
// each closed by a one-byte reply, and reports the result on four active-low LEDs.
// Assumptions: mem_rdata is an asynchronous read of mem_addr; rx_valid is a
// one-cycle strobe; img_len and erase_sel are sampled at the start edge.
module flash_prog_seq #(
    parameter int ADDR_W      = 16,
    parameter int CHUNK       = 256,
    parameter int DLY_W       = 24,
    parameter int TO_W        = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_n,
    input  logic [31:0]       img_len,
    input  logic [1:0]        erase_sel,
    input  logic [DLY_W-1:0]  led_delay,
    input  logic [TO_W-1:0]   ack_timeout,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_frame_err,
    input  logic              rx_overrun,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic [3:0]        led_n,
    output logic              busy
);
    import fps_pkg::*;

    localparam int LEN_BYTES = 4;
    localparam int LEN_W     = 8 * LEN_BYTES;
    localparam int CLOG_CH   = $clog2(CHUNK);
    localparam int IDX_W     = (CLOG_CH > 3) ? CLOG_CH : 3;

    seq_state_t        state;
    seq_phase_t        phase;
    logic [IDX_W-1:0]  idx;
    logic [LEN_W-1:0]  pos;
    logic [LEN_W-1:0]  len_q;
    logic [1:0]        sel_q;
    logic [3:0]        err_code;
    logic              show_go;
    logic              show_err;
    logic              start_fall;
    logic              tmo;
    logic              link_err;
    logic [IDX_W-1:0]  last_idx;
    logic [7:0]        len_byte;

    fps_start_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin_n(start_n), .fall(start_fall)
    );

    fps_ack_timer #(.TO_W(TO_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(state == ST_WAIT),
        .limit(ack_timeout), .expired(tmo)
    );

    fps_led_show #(.DLY_W(DLY_W), .N_LED(4)) u_leds (
        .clk(clk), .rst_n(rst_n), .clear(start_fall && !busy),
        .go(show_go), .err_mode(show_err), .code(err_code),
        .delay(led_delay), .led_n(led_n)
    );

    // Session status and handshake outputs from the state
    assign busy     = (state == ST_SEND) || (state == ST_WAIT);
    assign tx_valid = (state == ST_SEND);
    assign link_err = rx_valid && (rx_frame_err || rx_overrun);
    assign mem_addr = pos[ADDR_W-1:0];

    // Index of the last byte in the current stage
    always_comb begin
        unique case (phase)
            PH_HELLO: last_idx = '0;
            PH_ERASE: last_idx = IDX_W'(1);
            PH_LEN:   last_idx = IDX_W'(LEN_BYTES);
            default:  last_idx = IDX_W'(CHUNK - 1);
        endcase
    end

    // Length header byte, most significant first for idx 1..LEN_BYTES
    always_comb begin
        len_byte = 8'(len_q >> (8 * (LEN_BYTES - int'(idx))));
    end

    // Byte offered to the UART in the current stage
    always_comb begin
        unique case (phase)
            PH_HELLO: tx_data = CMD_START;
            PH_ERASE: tx_data = (idx == '0) ? CMD_ERASE : {6'b0, sel_q};
            PH_LEN:   tx_data = (idx == '0) ? CMD_PROG  : len_byte;
            default:  tx_data = (pos < len_q) ? mem_rdata : PAD_BYTE;
        endcase
    end

    // Main session state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            phase    <= PH_HELLO;
            idx      <= '0;
            pos      <= '0;
            len_q    <= '0;
            sel_q    <= '0;
            err_code <= '0;
            show_go  <= 1'b0;
            show_err <= 1'b0;
        end else begin
            show_go <= 1'b0;
            unique case (state)
                ST_SEND: begin
                    if (link_err) begin
                        state    <= ST_FAIL;
                        err_code <= ERR_LINK;
                        show_go  <= 1'b1;
                        show_err <= 1'b1;
                    end else if (tx_ready) begin
                        if (phase == PH_DATA) pos <= pos + 1'b1;
                        if (idx == last_idx) begin
                            idx   <= '0;
                            state <= ST_WAIT;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (link_err) begin
                        state    <= ST_FAIL;
                        err_code <= ERR_LINK;
                        show_go  <= 1'b1;
                        show_err <= 1'b1;
                    end else if (rx_valid && rx_data != REPLY_OK) begin
                        state    <= ST_FAIL;
                        err_code <= ERR_NAK;
                        show_go  <= 1'b1;
                        show_err <= 1'b1;
                    end else if (rx_valid) begin
                        unique case (phase)
                            PH_HELLO: begin phase <= PH_ERASE; state <= ST_SEND; end
                            PH_ERASE: begin phase <= PH_LEN;   state <= ST_SEND; end
                            PH_LEN: begin
                                if (len_q == '0) begin
                                    state    <= ST_DONE;
                                    show_go  <= 1'b1;
                                    show_err <= 1'b0;
                                end else begin
                                    phase <= PH_DATA;
                                    state <= ST_SEND;
                                end
                            end
                            default: begin
                                if (pos >= len_q) begin
                                    state    <= ST_DONE;
                                    show_go  <= 1'b1;
                                    show_err <= 1'b0;
                                end else begin
                                    state <= ST_SEND;
                                end
                            end
                        endcase
                    end else if (tmo) begin
                        state    <= ST_FAIL;
                        err_code <= ERR_TMO;
                        show_go  <= 1'b1;
                        show_err <= 1'b1;
                    end
                end
                default: begin
                    if (start_fall) begin
                        state <= ST_SEND;
                        phase <= PH_HELLO;
                        idx   <= '0;
                        pos   <= '0;
                        len_q <= img_len;
                        sel_q <= erase_sel;
                    end
                end
            endcase
        end
    end

    // R6
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !link_err) |=> (tx_valid && $stable(tx_data)));

    // R2
    first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (tx_valid && tx_data == 8'h10));

    // R10
    link_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && link_err) |=> !busy);

    // R10
    nak_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tx_valid && rx_valid && !link_err && rx_data != 8'h55) |=> !busy);
endmodule

// File: tb/sim_flash_prog_seq.sv
`timescale 1ns/1ps
module sim_flash_prog_seq;
    localparam int DLY = 5;
    localparam int TMO = 40;

    typedef struct packed {
        logic [31:0] len;
        logic [1:0]  sel;
        logic [3:0]  stall;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{32'd300, 2'd2, 4'd0},
        '{32'd256, 2'd0, 4'd2},
        '{32'd1,   2'd3, 4'd1},
        '{32'd0,   2'd1, 4'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n, start_n, tx_valid, tx_ready, rx_valid, rx_frame_err, rx_overrun, busy;
    logic [31:0] img_len;
    logic [1:0]  erase_sel;
    logic [23:0] led_delay;
    logic [19:0] ack_timeout;
    logic [7:0]  tx_data, rx_data, mem_rdata;
    logic [15:0] mem_addr;
    logic [3:0]  led_n;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    // Image model: byte k = k*37 + 11
    assign mem_rdata = 8'(32'(mem_addr) * 37 + 11);

    flash_prog_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_n(start_n), .img_len(img_len),
        .erase_sel(erase_sel), .led_delay(led_delay), .ack_timeout(ack_timeout),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_frame_err(rx_frame_err),
        .rx_overrun(rx_overrun), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .led_n(led_n), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic get_byte(output logic [7:0] b, input int stall);
        int n = 0;
        bit held = 1'b1;
        b = '0;
        while (!tx_valid && n < 5000) begin @(negedge clk); n++; end
        if (!tx_valid) begin chk(1'b0, "R6 no byte offered", 0, 1); return; end
        b = tx_data;
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            if (!tx_valid || tx_data != b) held = 1'b0;
        end
        if (stall > 0) chk(held, "R6 hold until ready", {23'b0, tx_valid, tx_data}, {24'b1, b});
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    task automatic expect_byte(input logic [7:0] exp, input int stall, input string req);
        logic [7:0] b;
        get_byte(b, stall);
        chk(b == exp, req, b, exp);
    endtask

    task automatic send_rx(input logic [7:0] d, input bit fe, input bit ov);
        rx_valid = 1'b1; rx_data = d; rx_frame_err = fe; rx_overrun = ov;
        @(negedge clk);
        rx_valid = 1'b0; rx_frame_err = 1'b0; rx_overrun = 1'b0;
    endtask

    task automatic start_session(input logic [31:0] len, input logic [1:0] sel);
        int n = 0;
        img_len = len; erase_sel = sel;
        if (!start_n) begin
            start_n = 1'b1;
            repeat (6) @(negedge clk);
            chk(!busy && !tx_valid, "R1 rising edge ignored", {busy, tx_valid}, 0);
        end
        start_n = 1'b0;
        while (!busy && n < 10) begin @(negedge clk); n++; end
        chk(busy, "R7 busy after start edge", busy, 1);
        chk(led_n == 4'hF, "R12 LEDs cleared at start", led_n, 4'hF);
    endtask

    task automatic check_chase();
        int n = 0;
        while (led_n == 4'hF && n < 20) begin @(negedge clk); n++; end
        for (int k = 0; k < 4; k++) begin
            logic [3:0] v = led_n;
            int d = 0;
            while (led_n == v && d < 100) begin d++; @(negedge clk); end
            chk(v == ~(4'b1 << k), "R9 chase pattern", v, ~(4'b1 << k));
            chk(d == DLY, "R9 step length", d, DLY);
        end
        chk(led_n == 4'hF, "R9 all off after chase", led_n, 4'hF);
        repeat (10) @(negedge clk);
        chk(led_n == 4'hF, "R9 stays off", led_n, 4'hF);
    endtask

    task automatic check_err(input logic [3:0] code, input string req);
        int n = 0;
        while (led_n == 4'hF && n < TMO + 40) begin @(negedge clk); n++; end
        for (int k = 0; k < 3; k++) begin
            logic [3:0] v = led_n;
            logic [3:0] e = (k % 2 == 1) ? 4'hF : ~code;
            int d = 0;
            while (led_n == v && d < 100) begin d++; @(negedge clk); end
            chk(v == e, {req, " error pattern"}, v, e);
            chk(d == DLY, "R10 blink phase length", d, DLY);
        end
    endtask

    task automatic run_ok(input logic [31:0] len, input logic [1:0] sel, input int stall);
        bit quiet = 1'b1;
        int nch;
        start_session(len, sel);
        expect_byte(8'h10, stall, "R2 start command");
        repeat (3) begin @(negedge clk); if (tx_valid) quiet = 1'b0; end
        chk(quiet, "R2 silent while waiting reply", tx_valid, 0);
        send_rx(8'h55, 1'b0, 1'b0);
        expect_byte(8'h11, stall, "R3 erase command");
        expect_byte({6'b0, sel}, stall, "R3 selector byte");
        send_rx(8'h55, 1'b0, 1'b0);
        expect_byte(8'h12, stall, "R4 program command");
        for (int j = 0; j < 4; j++)
            expect_byte(8'(len >> (8 * (3 - j))), stall, "R4 length byte MSB first");
        send_rx(8'h55, 1'b0, 1'b0);
        nch = int'((len + 255) / 256);
        for (int c = 0; c < nch; c++) begin
            for (int i = 0; i < 256; i++) begin
                int p = c * 256 + i;
                logic [7:0] e = (p < int'(len)) ? 8'(p * 37 + 11) : 8'hFF;
                expect_byte(e, stall, "R5 data or pad byte");
            end
            send_rx(8'h55, 1'b0, 1'b0);
        end
        chk(!busy && !tx_valid, "R7 busy low at done (R5 chunk count)", {busy, tx_valid}, 0);
        check_chase();
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        rst_n = 1'b0; start_n = 1'b1; tx_ready = 1'b0; rx_valid = 1'b0;
        rx_data = '0; rx_frame_err = 1'b0; rx_overrun = 1'b0;
        img_len = '0; erase_sel = '0; led_delay = 24'(DLY); ack_timeout = 20'(TMO);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk(led_n == 4'hF, "R8 LEDs off", led_n, 4'hF);
        chk(!busy && !tx_valid, "R8 idle outputs", {busy, tx_valid}, 0);

        // R10 wrong reply byte -> code 2
        start_session(32'd10, 2'd0);
        get_byte(b, 0);
        send_rx(8'h5A, 1'b0, 1'b0);
        chk(!busy && !tx_valid, "R10 stop on wrong reply", {busy, tx_valid}, 0);
        check_err(4'd2, "R10 code 2");

        // R10 framing error on reply -> code 1
        start_session(32'd10, 2'd1);
        get_byte(b, 0); send_rx(8'h55, 1'b0, 1'b0);
        get_byte(b, 0); get_byte(b, 0);
        send_rx(8'h55, 1'b1, 1'b0);
        chk(!busy, "R10 stop on framing error", busy, 0);
        check_err(4'd1, "R10 code 1 framing");

        // R10 overrun while a byte is offered -> code 1
        start_session(32'd10, 2'd1);
        get_byte(b, 0); send_rx(8'h55, 1'b0, 1'b0);
        chk(tx_valid, "R6 erase byte offered", tx_valid, 1);
        send_rx(8'h00, 1'b0, 1'b1);
        chk(!busy && !tx_valid, "R10 stop on overrun", {busy, tx_valid}, 0);
        check_err(4'd1, "R10 code 1 overrun");

        // R11 no reply -> code 3
        start_session(32'd10, 2'd1);
        get_byte(b, 0);
        repeat (TMO - 10) @(negedge clk);
        chk(busy, "R11 not expired early", busy, 1);
        check_err(4'd3, "R11 timeout code 3");
        chk(!busy, "R11 busy low after timeout", busy, 0);

        // Vector table of complete sessions (R12: first one leaves error state)
        for (int v = 0; v < 4; v++)
            run_ok(VEC[v].len, VEC[v].sel, int'(VEC[v].stall));

        // R1 held-low level and rising edge start nothing
        begin
            bit quiet = 1'b1;
            repeat (30) begin @(negedge clk); if (busy || tx_valid) quiet = 1'b0; end
            chk(quiet, "R1 held level ignored", {busy, tx_valid}, 0);
            start_n = 1'b1;
            quiet = 1'b1;
            repeat (30) begin @(negedge clk); if (busy || tx_valid) quiet = 1'b0; end
            chk(quiet, "R1 rising edge ignored", {busy, tx_valid}, 0);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule